// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator and Interrupt Flag Unit

This unit sits beside the time-of-day counters of a real-time clock. It holds three alarm bytes (seconds, minutes, hours) and compares them with the current time fields whenever the counters report a finished update. It keeps the interrupt flag byte and drives one level interrupt line. The unit gets the update-done strobe, the three time fields and a periodic tick from the rate divider. It owns the control bytes whose enable bits decide which events raise the interrupt.

Software reaches every location through a two-address port. An access at the even address loads a 7-bit pointer. An access at the odd address reads or writes the byte at that pointer. Read data is registered and appears the cycle after the read strobe. Locations that are not clock registers behave as plain byte storage. The flag byte clears itself when it is read, and that read is how software acknowledges the interrupt. Alarm bytes and time fields are compared as raw bytes, so both must use the same encoding.

Top module: `rtc_alarm_irq_ctrl`

## Requirements
- R1: After reset, location 0x0A reads 0x26, location 0x0B reads 0x02, the flag byte at 0x0C reads 0x00, location 0x0D reads 0x80, and `irq` is low.
- R2: A write at the even address (`bus_sel_data`=0) loads bits 6:0 of the write data as the pointer and drops bit 7. Odd-address accesses then target the location the pointer selects, out of 128.
- R3: Every location other than 0x01, 0x03, 0x05 and 0x0A to 0x0D stores the byte written to it. A read returns that byte on `bus_rdata` in the cycle after the read strobe.
- R4: The alarm bytes for seconds, minutes and hours are at 0x01, 0x03 and 0x05. Each reads back the value written to it.
- R5: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its time field. Any other alarm byte matches only an equal time byte.
- R6: If alarm enable (bit 5 of 0x0B) is set when `upd_done` pulses, and all three fields match, the unit sets flag bits 7 and 5. When the enable is clear, bit 5 stays clear.
- R7: Every `upd_done` pulse sets flag bit 4. If update enable (bit 4 of 0x0B) is set, the pulse also sets flag bit 7.
- R8: A `per_tick` pulse with periodic enable (bit 6 of 0x0B) set sets flag bits 6 and 7. With the enable clear, the pulse leaves the flags unchanged.
- R9: A read of location 0x0C returns the flag byte, then clears it to zero and drops `irq`.
- R10: Writes to locations 0x0C and 0x0D have no effect on what they read back or on `irq`.
- R11: An event that lands in the same cycle as a read of 0x0C is not lost. The read returns the flags from before the event, and the event's flags remain set afterwards.
- R12: `irq` is a level that follows flag bit 7. Once raised, it stays high until 0x0C is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_data | input | 1 | 0 selects the pointer port, 1 selects the data port |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (data port only) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| upd_done | input | 1 | One-cycle pulse when the time counters finish an update |
| tm_sec | input | 8 | Current seconds field |
| tm_min | input | 8 | Current minutes field |
| tm_hour | input | 8 | Current hours field |
| per_tick | input | 1 | One-cycle pulse from the periodic rate divider |
| irq | output | 1 | Level interrupt request |

## Verification
The bench writes pointer values with bit 7 set. A unit that kept that bit would reach the wrong location, and a wrong stored byte would show up when the location is read back. It fires update and periodic events with every mix of enables, using exact alarms, wildcard alarms and near misses. A comparator that ignores the wildcard bits, or that sets the alarm flag without its enable, would return a wrong flag byte. The hardest case puts an update pulse in the same cycle as a flag read. A unit that clears after setting would lose the event and leave `irq` low.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 7;
  localparam int N_ALARM = 3;

  // locations whose behaviour is fixed
  localparam logic [PTR_W-1:0] LOC_CTL_A = 7'h0A;
  localparam logic [PTR_W-1:0] LOC_CTL_B = 7'h0B;
  localparam logic [PTR_W-1:0] LOC_FLAGS = 7'h0C;
  localparam logic [PTR_W-1:0] LOC_STAT  = 7'h0D;

  // enable bits in the control byte at LOC_CTL_B
  localparam int EN_PER = 6;
  localparam int EN_ALM = 5;
  localparam int EN_UPD = 4;

  // bits in the flag byte
  localparam int FL_IRQ = 7;
  localparam int FL_PER = 6;
  localparam int FL_ALM = 5;
  localparam int FL_UPD = 4;

  localparam logic [BYTE_W-1:0] RST_CTL_A = 8'h26;
  localparam logic [BYTE_W-1:0] RST_CTL_B = 8'h02;
  localparam logic [BYTE_W-1:0] STAT_VAL  = 8'h80;
endpackage

// File: rtl/rtc_ptr_reg.sv
module rtc_ptr_reg #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ld) ptr_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic [N*W-1:0] alarm_flat,
  input  logic [N*W-1:0] time_flat,
  output logic           all_hit
);
  logic [N-1:0] fld_hit;

  for (genvar g = 0; g < N; g++) begin : g_fld
    logic [W-1:0] al;
    logic [W-1:0] tv;
    assign al = alarm_flat[g*W +: W];
    assign tv = time_flat[g*W +: W];
    // wildcard when both top bits are set
    assign fld_hit[g] = (al[W-1:W-2] == 2'b11) || (al == tv);
  end

  assign all_hit = &fld_hit;
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              per,
  input  logic              alm_hit,
  input  logic              en_per,
  input  logic              en_alm,
  input  logic              en_upd,
  output logic [BYTE_W-1:0] flags_q
);
  logic              set_per, set_alm, set_irq, fl_en;
  logic [BYTE_W-1:0] flags_d;

  always_comb begin
    set_per = per & en_per;
    set_alm = upd & en_alm & alm_hit;
    set_irq = set_per | set_alm | (upd & en_upd);
    fl_en   = clr | upd | per;
    // clear first, then merge this cycle's events so none is lost
    flags_d = clr ? '0 : flags_q;
    if (upd)     flags_d[FL_UPD] = 1'b1;
    if (set_alm) flags_d[FL_ALM] = 1'b1;
    if (set_per) flags_d[FL_PER] = 1'b1;
    if (set_irq) flags_d[FL_IRQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_q <= '0;
    else if (fl_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/rtc_alarm_irq_ctrl.sv
module rtc_alarm_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int IDX_W  = PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_data,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_done,
  input  logic [DATA_W-1:0] tm_sec,
  input  logic [DATA_W-1:0] tm_min,
  input  logic [DATA_W-1:0] tm_hour,
  input  logic              per_tick,
  output logic              irq
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]          idx_q;
  logic                      ptr_ld, data_wr, data_rd;
  logic [DATA_W-1:0]         a_q, b_q, flags_q;
  logic [DATA_W-1:0]         al_q [N_ALARM];
  logic [N_ALARM*DATA_W-1:0] al_flat;
  logic [N_ALARM-1:0]        al_sel;
  logic                      ctl_loc, mem_we, alm_hit, flags_rd;
  logic [DATA_W-1:0]         mem [DEPTH];
  logic [DATA_W-1:0]         rd_val;

  assign ptr_ld   = bus_wr & ~bus_sel_data;
  assign data_wr  = bus_wr &  bus_sel_data;
  assign data_rd  = bus_rd &  bus_sel_data;
  assign flags_rd = data_rd & (idx_q == LOC_FLAGS);

  rtc_ptr_reg #(.PTR_W(IDX_W)) i_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ptr_ld),
    .ld_val (bus_wdata[IDX_W-1:0]),
    .ptr_q  (idx_q)
  );

  // alarm bytes sit at odd locations 1, 3, 5
  for (genvar k = 0; k < N_ALARM; k++) begin : g_alarm
    assign al_sel[k] = (idx_q == IDX_W'(2*k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    al_q[k] <= '0;
      else if (data_wr && al_sel[k]) al_q[k] <= bus_wdata;
    end
    assign al_flat[k*DATA_W +: DATA_W] = al_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= RST_CTL_A;
      b_q <= RST_CTL_B;
    end else if (data_wr) begin
      if (idx_q == LOC_CTL_A) a_q <= bus_wdata;
      if (idx_q == LOC_CTL_B) b_q <= bus_wdata;
    end
  end

  rtc_alarm_cmp #(.N(N_ALARM), .W(DATA_W)) i_cmp (
    .alarm_flat (al_flat),
    .time_flat  ({tm_hour, tm_min, tm_sec}),
    .all_hit    (alm_hit)
  );

  rtc_flag_reg i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flags_rd),
    .upd     (upd_done),
    .per     (per_tick),
    .alm_hit (alm_hit),
    .en_per  (b_q[EN_PER]),
    .en_alm  (b_q[EN_ALM]),
    .en_upd  (b_q[EN_UPD]),
    .flags_q (flags_q)
  );

  assign irq = flags_q[FL_IRQ];

  // general-purpose storage for all remaining locations
  assign ctl_loc = (idx_q >= LOC_CTL_A) && (idx_q <= LOC_STAT);
  assign mem_we  = data_wr && !ctl_loc && (al_sel == '0);

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx_q] <= bus_wdata;
  end

  always_comb begin
    rd_val = mem[idx_q];
    for (int k = 0; k < N_ALARM; k++) begin
      if (al_sel[k]) rd_val = al_q[k];
    end
    if (idx_q == LOC_CTL_A) rd_val = a_q;
    if (idx_q == LOC_CTL_B) rd_val = b_q;
    if (idx_q == LOC_FLAGS) rd_val = flags_q;
    if (idx_q == LOC_STAT)  rd_val = STAT_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (data_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/rtc_irq_checker.sv
module rtc_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel_data,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       upd_done,
  input logic       per_tick,
  input logic       irq,
  input logic [6:0] idx_q,
  input logic [7:0] flags_q,
  input logic [7:0] ctl_b_q
);
  logic at_flags, quiet;
  assign at_flags = bus_sel_data && (idx_q == 7'h0C);
  assign quiet    = !upd_done && !per_tick;

  AST_UPD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flags_q[4]); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_flags && quiet) |=> (flags_q == 8'h00 && !irq)); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(upd_done || per_tick)); // R12

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_rd && at_flags)) |=> irq); // R12

  AST_ALM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[5]) |-> $past(ctl_b_q[5])); // R6

  AST_PER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[6]) |-> $past(ctl_b_q[6])); // R8

  AST_FLAG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_flags && !bus_rd && quiet) |=> $stable(flags_q)); // R10
endmodule

bind rtc_alarm_irq_ctrl rtc_irq_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel_data (bus_sel_data),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .upd_done     (upd_done),
  .per_tick     (per_tick),
  .irq          (irq),
  .idx_q        (idx_q),
  .flags_q      (flags_q),
  .ctl_b_q      (b_q)
);

// File: tb/test_rtc_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_alarm_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel_data, bus_wr, bus_rd, upd_done, per_tick;
  logic [7:0] bus_wdata, tm_sec, tm_min, tm_hour;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq_ctrl i_rtc_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel_data(bus_sel_data), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_done(upd_done), .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
    .per_tick(per_tick), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_sel_data = a0; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] d);
    @(negedge clk);
    bus_sel_data = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic put(input logic [7:0] loc, input logic [7:0] v);
    bus_write(1'b0, loc);
    bus_write(1'b1, v);
  endtask

  task automatic get(input logic [7:0] loc, output logic [7:0] v);
    bus_write(1'b0, loc);
    bus_read(v);
  endtask

  task automatic event_pulse(input logic u, input logic p,
                             input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    @(negedge clk);
    upd_done = u; per_tick = p; tm_sec = s; tm_min = m; tm_hour = h;
    @(negedge clk);
    upd_done = 1'b0; per_tick = 1'b0;
  endtask

  function automatic logic fld_ok(input logic [7:0] al, input logic [7:0] t);
    return (al[7:6] == 2'b11) || (al == t);
  endfunction

  function automatic logic [7:0] exp_flags(input logic [7:0] b, input logic u, input logic p,
                                           input logic hit);
    logic [7:0] f;
    f = 8'h00;
    if (u) f[4] = 1'b1;
    if (u && b[5] && hit) f[5] = 1'b1;
    if (p && b[6]) f[6] = 1'b1;
    if ((u && b[4]) || f[5] || f[6]) f[7] = 1'b1;
    return f;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] al [3];
    logic [7:0] tv [3];
    logic [7:0] b;
    logic       u, p, hit;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; bus_sel_data = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; upd_done = 1'b0; per_tick = 1'b0;
    tm_sec = '0; tm_min = '0; tm_hour = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    get(8'h0A, v); check("R1 loc 0x0A", v, 8'h26);
    get(8'h0B, v); check("R1 loc 0x0B", v, 8'h02);
    get(8'h0C, v); check("R1 loc 0x0C", v, 8'h00);
    get(8'h0D, v); check("R1 loc 0x0D", v, 8'h80);

    // R2 pointer bit 7 dropped
    put(8'hA0, 8'h5A);
    get(8'h20, v); check("R2 pointer 7 bits", v, 8'h5A);
    put(8'h20, 8'h11);
    get(8'hA0, v); check("R2 pointer alias", v, 8'h11);

    // R3 general storage
    put(8'h0E, 8'hC3); put(8'h7F, 8'h3C); put(8'h00, 8'h99);
    get(8'h0E, v); check("R3 loc 0x0E", v, 8'hC3);
    get(8'h7F, v); check("R3 loc 0x7F", v, 8'h3C);
    get(8'h00, v); check("R3 loc 0x00", v, 8'h99);

    // R4 alarm bytes
    put(8'h01, 8'h45); put(8'h03, 8'h12); put(8'h05, 8'h23);
    get(8'h01, v); check("R4 sec alarm", v, 8'h45);
    get(8'h03, v); check("R4 min alarm", v, 8'h12);
    get(8'h05, v); check("R4 hour alarm", v, 8'h23);

    // R10 writes to 0x0C and 0x0D ignored
    put(8'h0C, 8'hFF); put(8'h0D, 8'h00);
    check("R10 irq after write", {7'd0, irq}, 8'h00);
    get(8'h0C, v); check("R10 loc 0x0C", v, 8'h00);
    get(8'h0D, v); check("R10 loc 0x0D", v, 8'h80);

    // R7 update flag with and without enable
    event_pulse(1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
    check("R7 no irq", {7'd0, irq}, 8'h00);
    get(8'h0C, v); check("R7 flags no enable", v, 8'h10);
    put(8'h0B, 8'h12);
    event_pulse(1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
    check("R7 irq", {7'd0, irq}, 8'h01);
    // R12 held until read
    repeat (5) @(negedge clk);
    check("R12 irq held", {7'd0, irq}, 8'h01);
    get(8'h0C, v); check("R9 flags returned", v, 8'h90);
    check("R9 irq dropped", {7'd0, irq}, 8'h00);
    get(8'h0C, v); check("R9 flags cleared", v, 8'h00);

    // R5 R6 wildcard and exact alarms
    put(8'h0B, 8'h22);
    put(8'h01, 8'hC0); put(8'h03, 8'hFF); put(8'h05, 8'hC7);
    event_pulse(1'b1, 1'b0, 8'h37, 8'h59, 8'h13);
    get(8'h0C, v); check("R5 wildcard match", v, 8'hB0);
    put(8'h01, 8'h30); put(8'h03, 8'h15); put(8'h05, 8'h07);
    event_pulse(1'b1, 1'b0, 8'h31, 8'h15, 8'h07);
    check("R6 miss irq", {7'd0, irq}, 8'h00);
    get(8'h0C, v); check("R6 near miss", v, 8'h10);
    event_pulse(1'b1, 1'b0, 8'h30, 8'h15, 8'h07);
    get(8'h0C, v); check("R6 exact match", v, 8'hB0);
    put(8'h0B, 8'h02);
    event_pulse(1'b1, 1'b0, 8'h30, 8'h15, 8'h07);
    get(8'h0C, v); check("R6 match no enable", v, 8'h10);

    // R8 periodic
    event_pulse(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
    get(8'h0C, v); check("R8 tick no enable", v, 8'h00);
    put(8'h0B, 8'h42);
    event_pulse(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
    check("R8 irq", {7'd0, irq}, 8'h01);
    get(8'h0C, v); check("R8 tick enabled", v, 8'hC0);

    // R11 update in same cycle as flag read
    put(8'h0B, 8'h12);
    bus_write(1'b0, 8'h0C);
    @(negedge clk);
    bus_sel_data = 1'b1; bus_rd = 1'b1; upd_done = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; upd_done = 1'b0;
    check("R11 read returns old", bus_rdata, 8'h00);
    check("R11 irq kept", {7'd0, irq}, 8'h01);
    get(8'h0C, v); check("R11 event kept", v, 8'h90);

    // random mix: R5 R6 R7 R8 R9
    for (int i = 0; i < 200; i++) begin
      b = {1'b0, 3'($urandom), 4'h2};
      put(8'h0B, b);
      for (int k = 0; k < 3; k++) begin
        al[k] = ($urandom % 4 == 0) ? (8'hC0 | 8'($urandom % 8)) : 8'($urandom % 60);
        tv[k] = ($urandom % 3 == 0) ? 8'($urandom % 60) : al[k];
        if (tv[k][7:6] == 2'b11) tv[k] = 8'($urandom % 24);
        put(8'(2*k + 1), al[k]);
      end
      u = 1'($urandom);
      p = 1'($urandom);
      hit = fld_ok(al[0], tv[0]) && fld_ok(al[1], tv[1]) && fld_ok(al[2], tv[2]);
      event_pulse(u, p, tv[0], tv[1], tv[2]);
      v = exp_flags(b, u, p, hit);
      check("R12 random irq", {7'd0, irq}, {7'd0, v[7]});
      get(8'h0C, v);
      check("R6 R7 R8 random flags", v, exp_flags(b, u, p, hit));
      check("R9 random cleared", {7'd0, irq}, 8'h00);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule